// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that completes one instruction in every clock. It decodes nine instructions: five register-to-register operations (add, subtract, AND, OR, signed set-less-than), load word, store word, branch when two registers are equal, and an absolute jump. Inside the core are the program counter, a register bank of 32 words with two read ports and one write port, the ALU, the decode logic, and small word-addressed instruction and data memories.

Programs and initial data are placed through a single load port. A select bit on that port steers each word into either the instruction memory or the data memory. Execution is observed through debug outputs. These show the current PC and the register write that will take effect at the end of the current cycle. A typical run holds reset, loads code and data, releases reset, and follows the debug outputs cycle by cycle.

Top module: `cpu_core`

## Requirements
- R1: A synchronous reset forces the PC to 0 and clears every register to 0. While reset is high, the core writes neither registers nor data memory.
- R2: Load, store, R-type and undefined instructions advance the PC by 4.
- R3: An R-type instruction has opcode 0x00 and shift field [10:6] equal to 0. Funct 0x20 is add, 0x22 is subtract, 0x24 is AND and 0x25 is OR. The operands are the registers at [25:21] and [20:16], and the result is written to the register at [15:11].
- R4: An R-type instruction with funct 0x2A writes 1 when the register at [25:21] is less than the register at [20:16] as signed numbers. Otherwise it writes 0.
- R5: Load word (opcode 0x23) reads the data word at address reg[25:21] + sign-extended [15:0] and writes it to the register at [20:16].
- R6: Store word (opcode 0x2B) writes the register at [20:16] to the data word at the same computed address, and writes no register.
- R7: Branch-if-equal (opcode 0x04) sets PC to PC + 4 + (sign-extended [15:0] shifted left by 2) when both source registers are equal, and to PC + 4 otherwise. It writes no register.
- R8: Jump (opcode 0x02) sets PC to {(PC+4)[31:28], [25:0], 00} and writes no register.
- R9: Register 0 always reads as 0. A write aimed at it has no effect.
- R10: An unlisted opcode, or an R-type with an unlisted funct or a nonzero shift field, writes no register and no memory.
- R11: With progWe high, progData is written at the clock edge into the data memory (progDmem=1) or the instruction memory (progDmem=0). The word index is byte address bits [7:2] with the default depth of 64, so higher address bits alias. The same indexing applies to core accesses.
- R12: dbgPc shows the current PC. dbgRegWe, dbgRegAddr and dbgRegData show the register write that the current instruction commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Load-port write strobe |
| progDmem | input | 1 | Load-port target: 1 = data memory, 0 = instruction memory |
| progAddr | input | 32 | Load-port byte address |
| progData | input | 32 | Load-port write word |
| dbgPc | output | 32 | Current program counter |
| dbgRegWe | output | 1 | Register write committed this cycle |
| dbgRegAddr | output | 5 | Register write target |
| dbgRegData | output | 32 | Register write value |

## Verification
The bench builds the core with its default parameters: 32-bit words, 32 registers, and 64-word instruction and data memories. With 64-word memories, a load-port write to byte address 0x104 aliases onto word 1, so the bench can test address wrap with a short program. The stored program visits every opcode, signed comparison in both directions, a taken and a not-taken branch, a backward branch, a jump, a negative load offset, and a write aimed at register 0. A mid-run reset then shows that the registers were cleared while the data memory kept its contents.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JMP   = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   regWrite;
    logic   regDstRd;
    logic   aluSrcImm;
    logic   memWrite;
    logic   memToReg;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [XW-1:0] instr,
  output ctrl_t         ctrl
);

  logic [5:0] opcode;
  logic [5:0] funct;
  logic [4:0] shamt;
  logic       rValid;
  aluOp_e     rAluOp;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign shamt  = instr[10:6];

  // ALU function decode for register-to-register operations
  always_comb begin
    rValid = (shamt == 5'd0);
    rAluOp = ALU_ADD;
    unique case (funct)
      FN_ADD:  rAluOp = ALU_ADD;
      FN_SUB:  rAluOp = ALU_SUB;
      FN_AND:  rAluOp = ALU_AND;
      FN_OR:   rAluOp = ALU_OR;
      FN_SLT:  rAluOp = ALU_SLT;
      default: rValid = 1'b0;
    endcase
  end

  // Main decode; anything unlisted is a no-op
  always_comb begin
    ctrl = '{regWrite: 1'b0, regDstRd: 1'b0, aluSrcImm: 1'b0, memWrite: 1'b0,
             memToReg: 1'b0, branch: 1'b0, jump: 1'b0, aluOp: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = rValid;
        ctrl.regDstRd = 1'b1;
        ctrl.aluOp    = rAluOp;
      end
      OP_LW: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      OP_JMP:  ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int NREGS = 32,
  parameter int XW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [XW-1:0] rdDataA,
  output logic [XW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [XW-1:0] wrData
);

  logic [XW-1:0]    bank [NREGS];
  logic [NREGS-1:0] loadStb;

  // One load strobe per register; entry 0 never loads
  generate
    for (genvar g = 0; g < NREGS; g++) begin : gLoad
      if (g == 0) begin : gZero
        assign loadStb[g] = 1'b0;
      end else begin : gReg
        assign loadStb[g] = wrEn && (wrAddr == AW'(g));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (rst)             bank[i] <= '0;
      else if (loadStb[i]) bank[i] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : bank[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : bank[rdAddrB];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [XW-1:0] opA,
  input  logic [XW-1:0] opB,
  input  aluOp_e        op,
  output logic [XW-1:0] result,
  output logic          isZero
);

  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = XW'($signed(opA) < $signed(opB));
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int XW         = XLEN,
  parameter int NREGS      = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int RAW       = $clog2(NREGS),
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  ctrl_t          ctrl,
  input  logic           progWe,
  input  logic           progDmem,
  input  logic [XW-1:0]  progAddr,
  input  logic [XW-1:0]  progData,
  output logic [XW-1:0]  instr,
  output logic [XW-1:0]  pc,
  output logic           regWe,
  output logic [RAW-1:0] regWAddr,
  output logic [XW-1:0]  regWData
);

  logic [XW-1:0] imem [IMEM_WORDS];
  logic [XW-1:0] dmem [DMEM_WORDS];

  logic [XW-1:0] pcPlus4, brTarget, jTarget, pcNext;
  logic [XW-1:0] immExt, rsVal, rtVal, aluB, aluY, memRd;
  logic          aluZero;
  logic [IAW-1:0] fetchIdx, progIIdx;
  logic [DAW-1:0] dataIdx, progDIdx;

  // Fetch
  assign fetchIdx = IAW'(pc >> 2);
  assign instr    = imem[fetchIdx];

  // Operand selection
  assign immExt = {{(XW-16){instr[15]}}, instr[15:0]};
  assign aluB   = ctrl.aluSrcImm ? immExt : rtVal;

  cpu_regfile #(.NREGS(NREGS), .XW(XW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (instr[25:21]),
    .rdAddrB (instr[20:16]),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (regWe),
    .wrAddr  (regWAddr),
    .wrData  (regWData)
  );

  cpu_alu #(.XW(XW)) u_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluY),
    .isZero (aluZero)
  );

  // Data memory and load port
  assign dataIdx  = DAW'(aluY >> 2);
  assign progDIdx = DAW'(progAddr >> 2);
  assign progIIdx = IAW'(progAddr >> 2);
  assign memRd    = dmem[dataIdx];

  always_ff @(posedge clk) begin
    if (progWe && progDmem)          dmem[progDIdx] <= progData;
    else if (ctrl.memWrite && !rst)  dmem[dataIdx]  <= rtVal;
  end

  always_ff @(posedge clk) begin
    if (progWe && !progDmem) imem[progIIdx] <= progData;
  end

  // Write-back
  assign regWe    = ctrl.regWrite && !rst;
  assign regWAddr = ctrl.regDstRd ? instr[15:11] : instr[20:16];
  assign regWData = ctrl.memToReg ? memRd : aluY;

  // Next PC
  assign pcPlus4  = pc + XW'(4);
  assign brTarget = pcPlus4 + {immExt[XW-3:0], 2'b00};
  assign jTarget  = {pcPlus4[XW-1:XW-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  pcNext = jTarget;
    else if (ctrl.branch && aluZero) pcNext = brTarget;
    else                            pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int NREGS      = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        progWe,
  input  logic        progDmem,
  input  logic [31:0] progAddr,
  input  logic [31:0] progData,
  output logic [31:0] dbgPc,
  output logic        dbgRegWe,
  output logic [4:0]  dbgRegAddr,
  output logic [31:0] dbgRegData
);

  ctrl_t       ctrl;
  logic [31:0] instr;

  cpu_control #(.XW(XLEN)) u_ctl (
    .instr (instr),
    .ctrl  (ctrl)
  );

  cpu_datapath #(
    .XW(XLEN), .NREGS(NREGS), .IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .progWe   (progWe),
    .progDmem (progDmem),
    .progAddr (progAddr),
    .progData (progData),
    .instr    (instr),
    .pc       (dbgPc),
    .regWe    (dbgRegWe),
    .regWAddr (dbgRegAddr),
    .regWData (dbgRegData)
  );

endmodule

// File: rtl/cpu_core_checker.sv
module cpu_core_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] dbgPc,
  input logic        dbgRegWe,
  input logic [4:0]  dbgRegAddr
);

  logic [5:0]  op;
  logic [31:0] pcP4, jT, bT;
  logic        isFlow;

  assign op     = instr[31:26];
  assign pcP4   = dbgPc + 32'd4;
  assign jT     = {pcP4[31:28], instr[25:0], 2'b00};
  assign bT     = pcP4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign isFlow = (op == 6'h04) || (op == 6'h02);

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> dbgPc == 32'd0);

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !isFlow |=> dbgPc == $past(pcP4));

  a_r7_branch_pc: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04) |=> (dbgPc == $past(pcP4)) || (dbgPc == $past(bT)));

  a_r8_jump_pc: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> dbgPc == $past(jT));

  a_r5_load_target: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h23) |-> dbgRegWe && dbgRegAddr == instr[20:16]);

  a_r3_rtype_target: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h00) && dbgRegWe |-> dbgRegAddr == instr[15:11]);

  a_r6_store_nowrite: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h2B) |-> !dbgRegWe);

  a_r10_undef_nowrite: assert property (@(posedge clk) disable iff (rst)
    !(op inside {6'h00, 6'h23, 6'h2B, 6'h04, 6'h02}) |-> !dbgRegWe);

endmodule

bind cpu_core cpu_core_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr      (instr),
  .dbgPc      (dbgPc),
  .dbgRegWe   (dbgRegWe),
  .dbgRegAddr (dbgRegAddr)
);

// File: tb/sim_cpu_core.sv
module sim_cpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 24;
  localparam int NTRACE     = 20;

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
  } trace_t;

  // Expected per-cycle state while the stored program runs
  localparam trace_t TRACE [NTRACE] = '{
    '{32'h00, 1'b1, 5'd1,  32'd5},
    '{32'h04, 1'b1, 5'd2,  32'd7},
    '{32'h08, 1'b1, 5'd3,  32'hFFFF_FFFD},
    '{32'h0C, 1'b1, 5'd4,  32'd12},
    '{32'h10, 1'b1, 5'd5,  32'hFFFF_FFFE},
    '{32'h14, 1'b1, 5'd6,  32'd5},
    '{32'h18, 1'b1, 5'd7,  32'hFFFF_FFFD},
    '{32'h1C, 1'b1, 5'd8,  32'd1},
    '{32'h20, 1'b1, 5'd9,  32'd0},
    '{32'h24, 1'b0, 5'd0,  32'd0},
    '{32'h28, 1'b1, 5'd10, 32'd12},
    '{32'h2C, 1'b1, 5'd0,  32'd12},
    '{32'h30, 1'b1, 5'd11, 32'd5},
    '{32'h34, 1'b0, 5'd0,  32'd0},
    '{32'h38, 1'b0, 5'd0,  32'd0},
    '{32'h44, 1'b0, 5'd0,  32'd0},
    '{32'h50, 1'b0, 5'd0,  32'd0},
    '{32'h54, 1'b1, 5'd13, 32'hFFFF_FFFD},
    '{32'h58, 1'b0, 5'd0,  32'd0},
    '{32'h58, 1'b0, 5'd0,  32'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progWe = 1'b0;
  logic        progDmem = 1'b0;
  logic [31:0] progAddr = '0;
  logic [31:0] progData = '0;
  logic [31:0] dbgPc;
  logic        dbgRegWe;
  logic [4:0]  dbgRegAddr;
  logic [31:0] dbgRegData;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] prog [NPROG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_core u0 (
    .clk(clk), .rst(rst), .progWe(progWe), .progDmem(progDmem),
    .progAddr(progAddr), .progData(progData), .dbgPc(dbgPc),
    .dbgRegWe(dbgRegWe), .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );

  function automatic logic [31:0] rType(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iType(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic string tagFor(input logic [31:0] w);
    case (w[31:26])
      6'h23: return "R5";
      6'h2B: return "R6";
      6'h04: return "R7";
      6'h02: return "R8";
      6'h00: begin
        if (w[15:11] == 5'd0 || w[25:21] == 5'd0) return "R9";
        if (w[5:0] == 6'h2A) return "R4";
        return "R3";
      end
      default: return "R10";
    endcase
  endfunction

  function automatic string pcTagFor(input logic [31:0] w);
    case (w[31:26])
      6'h04:   return "R7";
      6'h02:   return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadWord(input logic toData, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    progWe = 1'b1; progDmem = toData; progAddr = addr; progData = data;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPROG; i++) prog[i] = '0;
    prog[0]  = iType(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1]  = iType(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2]  = iType(6'h23, 5'd0, 5'd3, 16'd8);
    prog[3]  = rType(5'd1, 5'd2, 5'd4, 6'h20);
    prog[4]  = rType(5'd1, 5'd2, 5'd5, 6'h22);
    prog[5]  = rType(5'd1, 5'd2, 5'd6, 6'h24);
    prog[6]  = rType(5'd1, 5'd3, 5'd7, 6'h25);
    prog[7]  = rType(5'd3, 5'd1, 5'd8, 6'h2A);
    prog[8]  = rType(5'd1, 5'd3, 5'd9, 6'h2A);
    prog[9]  = iType(6'h2B, 5'd0, 5'd4, 16'd12);
    prog[10] = iType(6'h23, 5'd0, 5'd10, 16'd12);
    prog[11] = rType(5'd1, 5'd2, 5'd0, 6'h20);
    prog[12] = rType(5'd0, 5'd1, 5'd11, 6'h20);
    prog[13] = iType(6'h04, 5'd1, 5'd2, 16'd5);
    prog[14] = iType(6'h04, 5'd1, 5'd6, 16'd2);
    prog[15] = rType(5'd1, 5'd1, 5'd12, 6'h20);
    prog[16] = rType(5'd2, 5'd2, 5'd12, 6'h20);
    prog[17] = {6'h02, 26'h14};
    prog[18] = rType(5'd1, 5'd1, 5'd12, 6'h20);
    prog[19] = rType(5'd1, 5'd1, 5'd12, 6'h20);
    prog[20] = 32'hFC00_0000;
    prog[21] = iType(6'h23, 5'd4, 5'd13, 16'hFFFC);
    prog[22] = iType(6'h04, 5'd0, 5'd0, 16'hFFFF);

    // Load data and code while reset holds (R11)
    loadWord(1'b1, 32'h0, 32'd5);
    loadWord(1'b1, 32'h4, 32'd7);
    loadWord(1'b1, 32'h8, 32'hFFFF_FFFD);
    for (int i = 0; i < NPROG; i++) loadWord(1'b0, 32'(i * 4), prog[i]);

    @(negedge clk);
    #1;
    check("R1 pc in reset", dbgPc, 32'd0);
    check("R1 no write in reset", {31'd0, dbgRegWe}, 32'd0);

    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NTRACE; i++) begin
      #1;
      check(i == 0 ? "R1 pc" : pcTagFor(prog[TRACE[i-1].pc >> 2]), dbgPc, TRACE[i].pc);
      check({"R12/", tagFor(prog[TRACE[i].pc >> 2]), " we"}, {31'd0, dbgRegWe},
            {31'd0, TRACE[i].we});
      if (TRACE[i].we) begin
        check({"R12/", tagFor(prog[TRACE[i].pc >> 2]), " addr"}, {27'd0, dbgRegAddr},
              {27'd0, TRACE[i].wa});
        check({"R12/", tagFor(prog[TRACE[i].pc >> 2]), " data"}, dbgRegData, TRACE[i].wd);
      end
      @(negedge clk);
    end

    // Directed: mid-run reset clears registers, data memory keeps contents,
    // and an aliased load-port address lands on word 1 (R1, R11)
    rst = 1'b1;
    loadWord(1'b0, 32'h0, rType(5'd4, 5'd5, 5'd14, 6'h20));
    loadWord(1'b1, 32'h104, 32'hA5A5_0001);
    #1;
    check("R1 pc after reset", dbgPc, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 cleared regs add sum", dbgRegData, 32'd0);
    check("R1 cleared regs addr", {27'd0, dbgRegAddr}, 32'd14);
    @(negedge clk);
    #1;
    check("R2 pc after add", dbgPc, 32'd4);
    check("R11 aliased data word", dbgRegData, 32'hA5A5_0001);
    @(negedge clk);
    #1;
    check("R11 unaliased data word", dbgRegData, 32'hFFFF_FFFD);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule